// File: doc/BRIEF.md
# Segment Address Translation Checker

This unit sits beside an address-generation stage. It turns a segment-relative effective offset into a linear address and decides whether the access must be refused with a general-protection fault. It holds six segment slots. Each slot has a base, a limit, a kind bit (code or data), a writable bit and a two-bit privilege level. A simple load port rewrites any slot. A request names a slot, an offset, an access size in bytes, an access kind, the current privilege level and an operating-mode flag. One cycle later the unit returns the linear address, the fault flag and a matching valid strobe.

In legacy or compatibility mode every slot contributes its base, and the 32-bit limit is enforced. In 64-bit mode the code, data, extra and stack slots act as if their base were zero. The two auxiliary slots still add their base. No limit is enforced in 64-bit mode, so the outcome depends on both the mode and the slot chosen. Slot encodings are 0 code, 1 data, 2 extra, 3 stack, 4 aux-F, 5 aux-G. Access kinds are 0 read, 1 write, 2 fetch and 3 reserved.

Top module: `segx_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_lin` and `rsp_gp` in that cycle belong to that request. `rsp_valid` is low in every other cycle.
- R2: After reset, `rsp_valid`, `rsp_lin` and `rsp_gp` are zero. The code slot holds base FFFF_0000h, limit FFFFh, kind code, not writable, privilege 0. So a fetch at offset FFF0h gives linear FFFF_FFF0h with no fault. Every other slot holds base 0, limit FFFFh, kind data, writable, privilege 0.
- R3: In legacy mode (`req_long`=0) the linear address is (base[31:0] + offset[31:0]) mod 2^32, zero-extended to 64 bits. Offset bits 63:32 have no effect.
- R4: In legacy mode the limit is inclusive. An access faults when offset[31:0] + size - 1, computed without wrap, is greater than the limit. A size of 0 counts as 1.
- R5: In 64-bit mode the code, data, extra and stack slots give linear address = the full 64-bit offset, whatever their base.
- R6: In 64-bit mode the aux-F and aux-G slots give linear address = (base + offset) mod 2^64.
- R7: In 64-bit mode no access faults because of the limit.
- R8: A write faults when the slot's kind is code or its writable bit is 0.
- R9: A read or write faults when `req_cpl` is numerically greater than the slot's privilege. Fetches are never refused for privilege.
- R10: A fetch faults when the slot is not the code slot or the slot's kind is data.
- R11: A slot encoding of 6 or 7, or access kind 3, always faults. For slot 6 or 7 the address is formed with base 0.
- R12: A load written in a cycle takes effect for requests from the next cycle on. A request in the same cycle as a load to its slot uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write the slot named by ld_sel |
| ld_sel | input | 3 | Slot to write |
| ld_base | input | 64 | New base |
| ld_limit | input | 32 | New inclusive limit |
| ld_code | input | 1 | New kind: 1 code, 0 data |
| ld_wr | input | 1 | New writable bit |
| ld_dpl | input | 2 | New privilege level |
| req_valid | input | 1 | Request present |
| req_seg | input | 3 | Slot used by the request |
| req_ofs | input | 64 | Effective offset |
| req_len | input | 4 | Access size in bytes |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_cpl | input | 2 | Current privilege level |
| req_long | input | 1 | 1 for 64-bit mode, 0 for legacy/compatibility |
| rsp_valid | output | 1 | Result present |
| rsp_lin | output | 64 | Linear address |
| rsp_gp | output | 1 | General-protection fault |

## Verification
Each result is due exactly one clock edge after the request is sampled. Loads become visible to requests sampled one edge after the load. The driver pushes the expected address and fault bit when it raises a request, on a falling edge. The monitor looks 1 ns after each rising edge. At that moment the queue head is due, and the monitor flags any valid strobe that shows up with nothing queued. The same-cycle load case is checked twice: once against the old slot contents and, one request later, against the new ones.

// File: rtl/segx_pkg.sv
package segx_pkg;

   localparam int SEL_W  = 3;
   localparam int NSEG   = 6;
   localparam int PL_W   = 2;
   localparam int KIND_W = 2;

   localparam logic [SEL_W-1:0] SEG_CS = 3'd0;
   localparam logic [SEL_W-1:0] SEG_DS = 3'd1;
   localparam logic [SEL_W-1:0] SEG_ES = 3'd2;
   localparam logic [SEL_W-1:0] SEG_SS = 3'd3;
   localparam logic [SEL_W-1:0] SEG_FS = 3'd4;
   localparam logic [SEL_W-1:0] SEG_GS = 3'd5;

   typedef enum logic [KIND_W-1:0] {
      ACC_RD    = 2'd0,
      ACC_WR    = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   // Slots whose base survives in 64-bit mode
   function automatic logic seg_base_kept(input logic [SEL_W-1:0] s);
      return (s == SEG_FS) || (s == SEG_GS);
   endfunction

endpackage

// File: rtl/segx_desc_file.sv
module segx_desc_file
   import segx_pkg::*;
#(
   parameter int          LIN_W       = 64,
   parameter int          LIMIT_W     = 32,
   parameter logic [63:0] RST_CS_BASE = 64'hFFFF_0000,
   parameter logic [31:0] RST_LIMIT   = 32'h0000_FFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [SEL_W-1:0]   ld_sel,
   input  logic [LIN_W-1:0]   ld_base,
   input  logic [LIMIT_W-1:0] ld_limit,
   input  logic               ld_code,
   input  logic               ld_wr,
   input  logic [PL_W-1:0]    ld_dpl,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic               rd_ok,
   output logic [LIN_W-1:0]   rd_base,
   output logic [LIMIT_W-1:0] rd_limit,
   output logic               rd_code,
   output logic               rd_wr,
   output logic [PL_W-1:0]    rd_dpl
);

   logic [LIN_W-1:0]   base_w  [NSEG];
   logic [LIMIT_W-1:0] limit_w [NSEG];
   logic               code_w  [NSEG];
   logic               wr_w    [NSEG];
   logic [PL_W-1:0]    dpl_w   [NSEG];

   for (genvar i = 0; i < NSEG; i++) begin : g_slot
      localparam bit IS_CODE = (i == int'(SEG_CS));
      localparam logic [LIN_W-1:0] RB = IS_CODE ? LIN_W'(RST_CS_BASE) : '0;
      logic [LIN_W-1:0]   base_q;
      logic [LIMIT_W-1:0] limit_q;
      logic               code_q;
      logic               wr_q;
      logic [PL_W-1:0]    dpl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q  <= RB;
            limit_q <= LIMIT_W'(RST_LIMIT);
            code_q  <= IS_CODE;
            wr_q    <= !IS_CODE;
            dpl_q   <= '0;
         end else if (ld_en && (ld_sel == SEL_W'(i))) begin
            base_q  <= ld_base;
            limit_q <= ld_limit;
            code_q  <= ld_code;
            wr_q    <= ld_wr;
            dpl_q   <= ld_dpl;
         end
      end

      assign base_w[i]  = base_q;
      assign limit_w[i] = limit_q;
      assign code_w[i]  = code_q;
      assign wr_w[i]    = wr_q;
      assign dpl_w[i]   = dpl_q;
   end

   assign rd_ok = (int'(rd_sel) < NSEG);

   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      rd_code  = 1'b0;
      rd_wr    = 1'b0;
      rd_dpl   = '0;
      for (int k = 0; k < NSEG; k++) begin
         if (rd_sel == SEL_W'(k)) begin
            rd_base  = base_w[k];
            rd_limit = limit_w[k];
            rd_code  = code_w[k];
            rd_wr    = wr_w[k];
            rd_dpl   = dpl_w[k];
         end
      end
   end

   // R12: a load is visible one edge later
   a_r12_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && (ld_sel == SEG_GS)) |=> (base_w[NSEG-1] == $past(ld_base)));

endmodule

// File: rtl/segx_addr_gen.sv
module segx_addr_gen #(
   parameter int LIN_W = 64,
   parameter int LEG_W = 32
) (
   input  logic             long_i,
   input  logic             keep_base_i,
   input  logic [LIN_W-1:0] base_i,
   input  logic [LIN_W-1:0] ofs_i,
   output logic [LIN_W-1:0] lin_o
);

   logic [LEG_W-1:0] leg_sum;
   logic [LIN_W-1:0] leg_lin;
   logic [LIN_W-1:0] long_lin;

   assign leg_sum  = base_i[LEG_W-1:0] + ofs_i[LEG_W-1:0];
   assign long_lin = ofs_i + (keep_base_i ? base_i : '0);

   if (LIN_W > LEG_W) begin : g_zext
      assign leg_lin = {{(LIN_W-LEG_W){1'b0}}, leg_sum};
   end else begin : g_same
      assign leg_lin = leg_sum;
   end

   assign lin_o = long_i ? long_lin : leg_lin;

endmodule

// File: rtl/segx_access_chk.sv
module segx_access_chk
   import segx_pkg::*;
#(
   parameter int LEG_W   = 32,
   parameter int LIMIT_W = 32,
   parameter int LEN_W   = 4
) (
   input  logic [SEL_W-1:0]   seg_i,
   input  logic               seg_ok_i,
   input  logic [LEG_W-1:0]   ofs_i,
   input  logic [LEN_W-1:0]   len_i,
   input  acc_e               kind_i,
   input  logic [PL_W-1:0]    cpl_i,
   input  logic               long_i,
   input  logic [LIMIT_W-1:0] limit_i,
   input  logic               code_i,
   input  logic               wr_i,
   input  logic [PL_W-1:0]    dpl_i,
   output logic               gp_o
);

   localparam int EW = LEG_W + 1;

   logic [LEN_W-1:0] len_eff;
   logic [EW-1:0]    last_byte;
   logic [EW-1:0]    limit_x;
   logic             f_limit, f_write, f_priv, f_fetch, f_bad;

   assign len_eff   = (len_i == '0) ? LEN_W'(1) : len_i;
   assign last_byte = {1'b0, ofs_i} + {{(EW-LEN_W){1'b0}}, len_eff} - EW'(1);
   assign limit_x   = {{(EW-LIMIT_W){1'b0}}, limit_i};

   always_comb begin
      f_limit = !long_i && (last_byte > limit_x);
      f_write = (kind_i == ACC_WR) && (code_i || !wr_i);
      f_priv  = ((kind_i == ACC_RD) || (kind_i == ACC_WR)) && (cpl_i > dpl_i);
      f_fetch = (kind_i == ACC_FETCH) && ((seg_i != SEG_CS) || !code_i);
      f_bad   = !seg_ok_i || (kind_i == ACC_RSVD);
      gp_o    = f_limit | f_write | f_priv | f_fetch | f_bad;
   end

endmodule

// File: rtl/segx_unit.sv
module segx_unit
   import segx_pkg::*;
#(
   parameter int LIN_W   = 64,
   parameter int LEG_W   = 32,
   parameter int LIMIT_W = 32,
   parameter int LEN_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [2:0]         ld_sel,
   input  logic [LIN_W-1:0]   ld_base,
   input  logic [LIMIT_W-1:0] ld_limit,
   input  logic               ld_code,
   input  logic               ld_wr,
   input  logic [1:0]         ld_dpl,
   input  logic               req_valid,
   input  logic [2:0]         req_seg,
   input  logic [LIN_W-1:0]   req_ofs,
   input  logic [LEN_W-1:0]   req_len,
   input  logic [1:0]         req_kind,
   input  logic [1:0]         req_cpl,
   input  logic               req_long,
   output logic               rsp_valid,
   output logic [LIN_W-1:0]   rsp_lin,
   output logic               rsp_gp
);

   if (LEG_W > LIN_W) begin : g_err_lin
      $error("segx_unit: LEG_W must not exceed LIN_W");
   end
   if (LIMIT_W > LEG_W) begin : g_err_lim
      $error("segx_unit: LIMIT_W must not exceed LEG_W");
   end
   if (LEN_W > LEG_W) begin : g_err_len
      $error("segx_unit: LEN_W must not exceed LEG_W");
   end

   logic               d_ok;
   logic [LIN_W-1:0]   d_base;
   logic [LIMIT_W-1:0] d_limit;
   logic               d_code;
   logic               d_wr;
   logic [PL_W-1:0]    d_dpl;
   logic [LIN_W-1:0]   lin_c;
   logic               gp_c;
   acc_e               kind_c;

   assign kind_c = acc_e'(req_kind);

   segx_desc_file #(
      .LIN_W   (LIN_W),
      .LIMIT_W (LIMIT_W)
   ) i_desc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_sel   (ld_sel),
      .ld_base  (ld_base),
      .ld_limit (ld_limit),
      .ld_code  (ld_code),
      .ld_wr    (ld_wr),
      .ld_dpl   (ld_dpl),
      .rd_sel   (req_seg),
      .rd_ok    (d_ok),
      .rd_base  (d_base),
      .rd_limit (d_limit),
      .rd_code  (d_code),
      .rd_wr    (d_wr),
      .rd_dpl   (d_dpl)
   );

   segx_addr_gen #(
      .LIN_W (LIN_W),
      .LEG_W (LEG_W)
   ) i_addr (
      .long_i      (req_long),
      .keep_base_i (seg_base_kept(req_seg)),
      .base_i      (d_base),
      .ofs_i       (req_ofs),
      .lin_o       (lin_c)
   );

   segx_access_chk #(
      .LEG_W   (LEG_W),
      .LIMIT_W (LIMIT_W),
      .LEN_W   (LEN_W)
   ) i_chk (
      .seg_i    (req_seg),
      .seg_ok_i (d_ok),
      .ofs_i    (req_ofs[LEG_W-1:0]),
      .len_i    (req_len),
      .kind_i   (kind_c),
      .cpl_i    (req_cpl),
      .long_i   (req_long),
      .limit_i  (d_limit),
      .code_i   (d_code),
      .wr_i     (d_wr),
      .dpl_i    (d_dpl),
      .gp_o     (gp_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_lin   <= '0;
         rsp_gp    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_lin <= lin_c;
            rsp_gp  <= gp_c;
         end
      end
   end

   // R1: one-cycle response timing
   a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R3: legacy addresses are zero-extended
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_long) |=> (rsp_lin[LIN_W-1:LEG_W] == '0));
   // R5: base ignored for the four flat slots in 64-bit mode
   a_r5_flat_base: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_long && (req_seg <= SEG_SS)) |=> (rsp_lin == $past(req_ofs)));
   // R6: aux slots keep their base in 64-bit mode
   a_r6_aux_base: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_long && ((req_seg == SEG_FS) || (req_seg == SEG_GS)))
      |=> (rsp_lin == $past(req_ofs + d_base)));
   // R8: writes into code slots are refused
   a_r8_code_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == ACC_WR) && d_code) |=> rsp_gp);
   // R9: data access from a less privileged level is refused
   a_r9_priv: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == ACC_RD || req_kind == ACC_WR) && (req_cpl > d_dpl)) |=> rsp_gp);
   // R10: fetch only through the code slot
   a_r10_fetch_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == ACC_FETCH) && (req_seg != SEG_CS)) |=> rsp_gp);
   // R11: illegal encodings fault
   a_r11_bad_enc: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_seg > SEG_GS) || (req_kind == ACC_RSVD))) |=> rsp_gp);

endmodule

// File: tb/test_segx_unit.sv
module test_segx_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_sel = '0;
   logic [63:0] ld_base = '0;
   logic [31:0] ld_limit = '0;
   logic        ld_code = 1'b0;
   logic        ld_wr = 1'b0;
   logic [1:0]  ld_dpl = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_seg = '0;
   logic [63:0] req_ofs = '0;
   logic [3:0]  req_len = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_cpl = '0;
   logic        req_long = 1'b0;
   logic        rsp_valid;
   logic [63:0] rsp_lin;
   logic        rsp_gp;

   always #10 clk = ~clk;

   segx_unit i_segx_unit (.*);

   typedef struct {
      logic [63:0] lin;
      logic        gp;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // Monitor: results are due one edge after the request
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (!rsp_valid || rsp_lin !== e.lin || rsp_gp !== e.gp) begin
               n_bad++;
               $display("FAIL %s: valid=%0b lin=%h gp=%0b expected valid=1 lin=%h gp=%0b",
                        e.tag, rsp_valid, rsp_lin, rsp_gp, e.lin, e.gp);
            end
         end else if (rsp_valid) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1: spurious rsp_valid=1 expected 0");
         end
      end
   end

   task automatic put(input logic [2:0] seg, input logic [63:0] ofs, input logic [3:0] len,
                      input logic [1:0] kind, input logic [1:0] cpl, input logic lng,
                      input logic [63:0] elin, input logic egp, input string tag);
      exp_t e;
      req_valid = 1'b1;
      req_seg   = seg;
      req_ofs   = ofs;
      req_len   = len;
      req_kind  = kind;
      req_cpl   = cpl;
      req_long  = lng;
      e.lin = elin; e.gp = egp; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic req(input logic [2:0] seg, input logic [63:0] ofs, input logic [3:0] len,
                      input logic [1:0] kind, input logic [1:0] cpl, input logic lng,
                      input logic [63:0] elin, input logic egp, input string tag);
      @(negedge clk);
      put(seg, ofs, len, kind, cpl, lng, elin, egp, tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_ld(input logic [2:0] sel, input logic [63:0] base, input logic [31:0] lim,
                         input logic code, input logic wr, input logic [1:0] dpl);
      ld_en = 1'b1; ld_sel = sel; ld_base = base; ld_limit = lim;
      ld_code = code; ld_wr = wr; ld_dpl = dpl;
   endtask

   task automatic load(input logic [2:0] sel, input logic [63:0] base, input logic [31:0] lim,
                       input logic code, input logic wr, input logic [1:0] dpl);
      @(negedge clk);
      set_ld(sel, base, lim, code, wr, dpl);
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_vec++;
      if (rsp_valid !== 1'b0 || rsp_lin !== 64'h0 || rsp_gp !== 1'b0) begin
         n_bad++;
         $display("FAIL R2: reset outputs valid=%0b lin=%h gp=%0b expected 0 0 0",
                  rsp_valid, rsp_lin, rsp_gp);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2: reset descriptors
      req(3'd0, 64'hFFF0, 4'd1, 2'd2, 2'd0, 1'b0, 64'hFFFF_FFF0, 1'b0, "R2");
      req(3'd1, 64'h1234, 4'd1, 2'd0, 2'd0, 1'b0, 64'h1234, 1'b0, "R2");
      // R4: inclusive limit
      req(3'd1, 64'hFFFF, 4'd1, 2'd0, 2'd0, 1'b0, 64'hFFFF, 1'b0, "R4");
      req(3'd1, 64'hFFFF, 4'd2, 2'd0, 2'd0, 1'b0, 64'hFFFF, 1'b1, "R4");
      req(3'd1, 64'hFFFC, 4'd4, 2'd0, 2'd0, 1'b0, 64'hFFFC, 1'b0, "R4");
      req(3'd1, 64'hFFFF, 4'd0, 2'd0, 2'd0, 1'b0, 64'hFFFF, 1'b0, "R4");

      // R3: base add, upper offset ignored, wrap
      load(3'd1, 64'h1000_0000, 32'h0000_FFFF, 1'b0, 1'b1, 2'd3);
      req(3'd1, 64'hFFFF_FFFF_0000_0010, 4'd1, 2'd0, 2'd0, 1'b0, 64'h1000_0010, 1'b0, "R3");
      load(3'd2, 64'hFFFF_FFF0, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0);
      req(3'd2, 64'h20, 4'd1, 2'd0, 2'd0, 1'b0, 64'h10, 1'b0, "R3");

      // R8: write protection
      req(3'd0, 64'h10, 4'd1, 2'd1, 2'd0, 1'b0, 64'hFFFF_0010, 1'b1, "R8");
      load(3'd3, 64'h2000, 32'h0000_FFFF, 1'b0, 1'b0, 2'd0);
      req(3'd3, 64'h8, 4'd4, 2'd1, 2'd0, 1'b0, 64'h2008, 1'b1, "R8");
      req(3'd3, 64'h8, 4'd4, 2'd0, 2'd0, 1'b0, 64'h2008, 1'b0, "R8");
      req(3'd1, 64'h8, 4'd4, 2'd1, 2'd3, 1'b0, 64'h1000_0008, 1'b0, "R8");

      // R9: privilege
      req(3'd2, 64'h20, 4'd1, 2'd0, 2'd3, 1'b0, 64'h10, 1'b1, "R9");
      req(3'd1, 64'h20, 4'd1, 2'd0, 2'd3, 1'b0, 64'h1000_0020, 1'b0, "R9");
      req(3'd0, 64'h10, 4'd1, 2'd2, 2'd3, 1'b0, 64'hFFFF_0010, 1'b0, "R9");

      // R10: fetch through data slot
      req(3'd1, 64'h4, 4'd1, 2'd2, 2'd0, 1'b0, 64'h1000_0004, 1'b1, "R10");

      // R11: bad encodings
      req(3'd6, 64'h44, 4'd1, 2'd0, 2'd0, 1'b0, 64'h44, 1'b1, "R11");
      req(3'd1, 64'h10, 4'd1, 2'd3, 2'd0, 1'b0, 64'h1000_0010, 1'b1, "R11");

      // R5, R6, R7: 64-bit mode
      load(3'd4, 64'h0000_7000_0000_0000, 32'h0, 1'b0, 1'b1, 2'd3);
      req(3'd4, 64'h100, 4'd1, 2'd0, 2'd0, 1'b1, 64'h0000_7000_0000_0100, 1'b0, "R6");
      req(3'd4, 64'h100, 4'd1, 2'd0, 2'd0, 1'b0, 64'h100, 1'b1, "R4");
      req(3'd1, 64'h1_2345_6789, 4'd1, 2'd0, 2'd0, 1'b1, 64'h1_2345_6789, 1'b0, "R5");
      req(3'd1, 64'h1_2345_6789, 4'd1, 2'd0, 2'd0, 1'b0, 64'h3345_6789, 1'b1, "R7");
      req(3'd3, 64'hABCD_0000_0000_0000, 4'd8, 2'd0, 2'd0, 1'b1, 64'hABCD_0000_0000_0000, 1'b0, "R7");
      load(3'd5, 64'hFFFF_FFFF_FFFF_F000, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0);
      req(3'd5, 64'h2000, 4'd1, 2'd0, 2'd0, 1'b1, 64'h1000, 1'b0, "R6");

      // R12: load and request in the same cycle
      @(negedge clk);
      set_ld(3'd5, 64'h5000, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0);
      put(3'd5, 64'h4, 4'd1, 2'd0, 2'd0, 1'b0, 64'hFFFF_F004, 1'b0, "R12");
      @(negedge clk);
      ld_en = 1'b0;
      put(3'd5, 64'h4, 4'd1, 2'd0, 2'd0, 1'b0, 64'h5004, 1'b0, "R12");
      @(negedge clk);
      req_valid = 1'b0;

      // R10: code slot reloaded as data
      load(3'd0, 64'h0, 32'h0000_FFFF, 1'b0, 1'b1, 2'd0);
      req(3'd0, 64'h0, 4'd1, 2'd2, 2'd0, 1'b0, 64'h0, 1'b1, "R10");

      // R1: idle cycles stay quiet
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule